// File: doc/BRIEF.md
# LUT4 Flip-Flop Logic Tile

A tile of configurable logic slices for a small programmable fabric. Each slice evaluates any Boolean function of its four inputs through a 16-entry truth table. The slice also holds one D flip-flop. The flip-flop captures either the table result or the slice's fourth input directly, which gives a bypass path. The slice output is either the combinational table result or the registered value.

Each flip-flop advances only on the cycles in which its chosen candidate clock line is high. The choice comes from a small set of lines that enter the tile, so slices in one tile can run at different rates.

All configuration enters through one serial shift chain that runs through every slice. While the chain is loading, every flip-flop holds its value and every slice output is driven low. Half-written configuration therefore never reaches downstream logic. A synchronous active-low reset clears all flip-flops and all configuration.

Top module: `lut_tile`

## Requirements
- R1: With the configuration chain idle and the output source set to combinational, slice output s equals truth-table bit number {in3,in2,in1,in0} of slice s. The slice inputs are `lut_in[4s+3:4s]`, and input 0 is the least significant index bit.
- R2: A truth table of 16'hFFFF makes the slice output 1 for every input combination, and 16'h0000 makes it 0 for every input combination.
- R3: When the data-source bit is 0, the flip-flop captures the truth-table result on an enabled cycle.
- R4: When the data-source bit is 1, the flip-flop captures slice input 3 directly and ignores the truth table.
- R5: The output-source bit picks the slice output: 0 selects the combinational table result and 1 selects the flip-flop value.
- R6: A slice's flip-flop loads only at a clock edge where `clk_lines[csel]` is high, with csel taken from that slice's clock-select field. At every other edge it keeps its value.
- R7: Each slice uses only its own inputs and its own configuration word, so slices evaluate independently.
- R8: Each cycle with `cfg_en` high shifts `cfg_in` into the top of the chain, and every bit moves one place toward bit 0. Once NUM_SLICES*20 bits have been shifted in, the first bit sits at chain bit 0. Slice s owns chain bits [20s+19:20s], laid out as truth table in bits 0..15 (bit i is entry i), data source in bit 16, output source in bit 17, and clock select in bits 18..19. The chain does not change while `cfg_en` is low.
- R9: While `cfg_en` is high, every slice output is 0 and every flip-flop holds its value, including when its clock line is high.
- R10: `cfg_out` shows the chain's bit 0, which is the bit shifted in NUM_SLICES*20 shifts earlier.
- R11: A clock edge with `rst_n` low clears every flip-flop and every configuration bit, so all slice outputs read 0 afterward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable; holds the tile inert |
| cfg_in | input | 1 | Serial configuration bit |
| cfg_out | output | 1 | Chain tail, for daisy-chaining tiles |
| clk_lines | input | NUM_CLK_LINES | Candidate clock lines entering the tile |
| lut_in | input | 4*NUM_SLICES | Four inputs per slice, slice s at [4s+3:4s] |
| slice_out | output | NUM_SLICES | One output per slice |

## Verification
The bench loads a different truth table into each slice and gives each slice a different input value on every step, over all 16 index values. This exposes a reversed index order or crossed slice wiring, which would show up as wrong bits for some slices. It then covers the bypass path with a table that returns constant 0 while input 3 is 1, so a flip-flop fed from the wrong source reads 0. The clock-select test pulses lines that are not selected and checks that a slice listening to the wrong line updates early. A hold test keeps the selected line high through a full reload. A design that let the flip-flop run during configuration would then lose its stored 1. The bench also checks the exact shift at which a marker bit reaches the chain tail, which catches an off-by-one chain length.

// File: rtl/lut_tile_pkg.sv
// Package: shared constants and selector encodings for the logic tile.
// Assumes four-input lookup tables throughout the fabric.
package lut_tile_pkg;
    localparam int LUT_K       = 4;
    localparam int LUT_ENTRIES = 1 << LUT_K;

    // Flip-flop data source, one configuration bit.
    typedef enum logic {
        DSRC_LUT    = 1'b0,
        DSRC_BYPASS = 1'b1
    } dsrc_e;

    // Slice output source, one configuration bit.
    typedef enum logic {
        OSRC_COMB = 1'b0,
        OSRC_REG  = 1'b1
    } osrc_e;

    // Width of one slice's configuration word for a given clock-select width.
    function automatic int slice_cfg_bits(input int csel_w);
        return LUT_ENTRIES + 2 + csel_w;
    endfunction
endpackage

// File: rtl/lut_tile_cfg_chain.sv
// Module: serial configuration shift register.
// Each shift enters a bit at the top and moves every bit one place toward
// bit 0, so the first bit shifted in ends at bit 0 after CHAIN_BITS shifts.
// Assumes CHAIN_BITS >= 2.
module lut_tile_cfg_chain #(
    parameter int CHAIN_BITS = 160
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic                  bit_in,
    output logic [CHAIN_BITS-1:0] chain_q,
    output logic                  bit_out
);
    logic [CHAIN_BITS-1:0] chain_r;

    // Purpose: clear on reset, otherwise shift one bit per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_r <= '0;
        end else if (shift_en) begin
            chain_r <= {bit_in, chain_r[CHAIN_BITS-1:1]};
        end
    end

    assign chain_q = chain_r;
    assign bit_out = chain_r[0];
endmodule

// File: rtl/lut_tile_lut4.sv
// Module: four-input lookup table evaluation.
// The input vector indexes the truth table, with input 0 as the LSB.
module lut_tile_lut4
    import lut_tile_pkg::*;
(
    input  logic [LUT_ENTRIES-1:0] truth_tbl,
    input  logic [LUT_K-1:0]       sel,
    output logic                   y
);
    // Purpose: read the selected truth-table entry.
    always_comb begin
        y = truth_tbl[sel];
    end
endmodule

// File: rtl/lut_tile_slice.sv
// Module: one logic slice, with a LUT, a data-source mux, a flip-flop gated by
// its selected clock line, and an output-source mux.
// Assumes cfg_word is stable whenever cfg_busy is low.
module lut_tile_slice
    import lut_tile_pkg::*;
#(
    parameter int NUM_CLK_LINES = 4,
    parameter int CSEL_W        = 2,
    localparam int SLICE_BITS   = LUT_ENTRIES + 2 + CSEL_W,
    localparam int PAD_LINES    = 1 << CSEL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_busy,
    input  logic [SLICE_BITS-1:0]    cfg_word,
    input  logic [NUM_CLK_LINES-1:0] clk_lines,
    input  logic [LUT_K-1:0]         lut_in,
    output logic                     out,
    output logic                     ff_q
);
    logic [LUT_ENTRIES-1:0] truth_tbl;
    dsrc_e                  dsrc;
    osrc_e                  osrc;
    logic [CSEL_W-1:0]      csel;
    logic                   lut_y;
    logic                   ff_d;
    logic                   tick;
    logic                   q_r;

    assign truth_tbl = cfg_word[LUT_ENTRIES-1:0];
    assign dsrc      = dsrc_e'(cfg_word[LUT_ENTRIES]);
    assign osrc      = osrc_e'(cfg_word[LUT_ENTRIES+1]);
    assign csel      = cfg_word[LUT_ENTRIES+2 +: CSEL_W];

    lut_tile_lut4 lut_i (
        .truth_tbl (truth_tbl),
        .sel       (lut_in),
        .y         (lut_y)
    );

    // Clock-line pick: a select code with no matching line never fires.
    generate
        if (PAD_LINES == NUM_CLK_LINES) begin : g_full
            assign tick = clk_lines[csel];
        end else begin : g_pad
            logic [PAD_LINES-1:0] lines_pad;
            assign lines_pad = {{(PAD_LINES-NUM_CLK_LINES){1'b0}}, clk_lines};
            assign tick = lines_pad[csel];
        end
    endgenerate

    // Purpose: choose the flip-flop data source.
    always_comb begin
        ff_d = (dsrc == DSRC_BYPASS) ? lut_in[LUT_K-1] : lut_y;
    end

    // Purpose: load on selected-line cycles, hold while configuring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= 1'b0;
        end else if (!cfg_busy && tick) begin
            q_r <= ff_d;
        end
    end

    // Purpose: choose the slice output, forced low during configuration.
    always_comb begin
        if (cfg_busy) begin
            out = 1'b0;
        end else if (osrc == OSRC_REG) begin
            out = q_r;
        end else begin
            out = lut_y;
        end
    end

    assign ff_q = q_r;
endmodule

// File: rtl/lut_tile.sv
// Module: tile of NUM_SLICES logic slices sharing one configuration chain
// and a set of candidate clock lines.
// Assumes NUM_CLK_LINES >= 2 and NUM_SLICES >= 1.
module lut_tile
    import lut_tile_pkg::*;
#(
    parameter int NUM_SLICES    = 8,
    parameter int NUM_CLK_LINES = 4,
    localparam int CSEL_W       = (NUM_CLK_LINES > 1) ? $clog2(NUM_CLK_LINES) : 1,
    localparam int SLICE_BITS   = LUT_ENTRIES + 2 + CSEL_W,
    localparam int CHAIN_BITS   = NUM_SLICES * SLICE_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_en,
    input  logic                        cfg_in,
    output logic                        cfg_out,
    input  logic [NUM_CLK_LINES-1:0]    clk_lines,
    input  logic [LUT_K*NUM_SLICES-1:0] lut_in,
    output logic [NUM_SLICES-1:0]       slice_out
);
    logic [CHAIN_BITS-1:0] cfg_vec;
    logic [NUM_SLICES-1:0] ff_q_all;

    lut_tile_cfg_chain #(
        .CHAIN_BITS (CHAIN_BITS)
    ) chain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .bit_in   (cfg_in),
        .chain_q  (cfg_vec),
        .bit_out  (cfg_out)
    );

    // One slice per chain segment.
    generate
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
            lut_tile_slice #(
                .NUM_CLK_LINES (NUM_CLK_LINES),
                .CSEL_W        (CSEL_W)
            ) slice_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg_busy  (cfg_en),
                .cfg_word  (cfg_vec[s*SLICE_BITS +: SLICE_BITS]),
                .clk_lines (clk_lines),
                .lut_in    (lut_in[s*LUT_K +: LUT_K]),
                .out       (slice_out[s]),
                .ff_q      (ff_q_all[s])
            );
        end
    endgenerate
endmodule

// File: rtl/lut_tile_chk.sv
// Module: protocol checker for lut_tile, attached by bind below.
// Observes ports, the configuration chain and the flip-flop states.
module lut_tile_chk #(
    parameter int NUM_SLICES = 8,
    parameter int CHAIN_BITS = 160
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_en,
    input logic                  cfg_in,
    input logic [NUM_SLICES-1:0] slice_out,
    input logic [NUM_SLICES-1:0] ff_q,
    input logic [CHAIN_BITS-1:0] cfg_vec
);
    // R9: outputs are quiet while configuring.
    p_quiet_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (slice_out == '0));

    // R9: flip-flops hold across a configuring cycle.
    p_ff_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> $stable(ff_q));

    // R11: reset clears flip-flops and configuration.
    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> ((ff_q == '0) && (cfg_vec == '0)));

    // R8: the chain is frozen when not shifting.
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cfg_en) |=> $stable(cfg_vec));

    // R8: a shift places the serial bit at the chain top.
    p_shift_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_vec[CHAIN_BITS-1] == $past(cfg_in)));
endmodule

bind lut_tile lut_tile_chk #(
    .NUM_SLICES (NUM_SLICES),
    .CHAIN_BITS (CHAIN_BITS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_in    (cfg_in),
    .slice_out (slice_out),
    .ff_q      (ff_q_all),
    .cfg_vec   (cfg_vec)
);

// File: tb/lut_tile_tb_top.sv
module lut_tile_tb_top;
    localparam int NS  = 8;
    localparam int NL  = 4;
    localparam int SB  = 20;
    localparam int TOT = NS * SB;
    localparam logic [15:0] TBL [8] = '{16'hA55A, 16'h8001, 16'h6996, 16'hF00F,
                                        16'h1234, 16'hCAFE, 16'h0F3C, 16'h7E81};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n, cfg_en, cfg_in;
    logic [NL-1:0]     lines;
    logic [NS*4-1:0]   lin;
    logic              cfg_out;
    logic [NS-1:0]     sout;
    logic [SB-1:0]     words [NS];
    int                checks = 0;
    int                errors = 0;
    bit                done = 1'b0;

    lut_tile dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_en (cfg_en), .cfg_in (cfg_in),
        .cfg_out (cfg_out), .clk_lines (lines), .lut_in (lin), .slice_out (sout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [SB-1:0] mkw(input logic [15:0] t, input logic d,
                                          input logic o, input logic [1:0] cs);
        return {cs, o, d, t};
    endfunction

    // Shift all slice words in, bit 0 of slice 0 first (R8).
    task automatic load();
        logic [TOT-1:0] vec;
        for (int s = 0; s < NS; s++) vec[s*SB +: SB] = words[s];
        for (int i = 0; i < TOT; i++) begin
            cfg_en = 1'b1;
            cfg_in = vec[i];
            @(posedge clk); #1;
            if (i == TOT/2) begin
                @(negedge clk);
                chk("R9 quiet during load", 32'(sout), 32'h0);
            end
        end
        cfg_en = 1'b0;
        cfg_in = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, run incomplete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_en = 1'b0; cfg_in = 1'b0; lines = '0; lin = '0;
        repeat (3) @(posedge clk);
        #1; @(negedge clk);
        chk("R11 reset outputs", 32'(sout), 32'h0);
        chk("R11 reset chain tail", 32'(cfg_out), 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R10: marker bit reaches the tail exactly after TOT shifts.
        for (int i = 1; i <= TOT; i++) begin
            cfg_en = 1'b1;
            cfg_in = (i == 1);
            @(posedge clk); #1;
            if (i == TOT-1) chk("R10 tail before arrival", 32'(cfg_out), 32'h0);
            if (i == TOT)   chk("R10 tail at arrival", 32'(cfg_out), 32'h1);
        end
        cfg_en = 1'b0; cfg_in = 1'b0;

        // R1, R7, R5: table-driven sweep, distinct table and input per slice.
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < NS; s++) words[s] = mkw(TBL[(k+s)%8], 1'b0, 1'b0, 2'd0);
            load();
            for (int v = 0; v < 16; v++) begin
                logic [NS-1:0] exp;
                for (int s = 0; s < NS; s++) begin
                    lin[s*4 +: 4] = 4'((v+s)%16);
                    exp[s] = TBL[(k+s)%8][(v+s)%16];
                end
                @(negedge clk);
                chk("R1 R7 R5 comb lookup", 32'(sout), 32'(exp));
                @(posedge clk); #1;
            end
        end

        // R2: constant sources.
        for (int s = 0; s < NS; s++) words[s] = mkw(16'h0, 1'b0, 1'b0, 2'd0);
        words[0] = mkw(16'hFFFF, 1'b0, 1'b0, 2'd0);
        words[1] = mkw(16'h0000, 1'b0, 1'b0, 2'd0);
        load();
        for (int v = 0; v < 16; v++) begin
            lin = {NS{4'(v)}};
            @(negedge clk);
            chk("R2 constant high", 32'(sout[0]), 32'h1);
            chk("R2 constant low", 32'(sout[1]), 32'h0);
            @(posedge clk); #1;
        end

        // R3, R5: LUT-fed flip-flop, registered output.
        for (int s = 0; s < NS; s++) words[s] = mkw(16'h0, 1'b0, 1'b0, 2'd0);
        words[0] = mkw(16'h8000, 1'b0, 1'b1, 2'd0);
        lin = '0; load();
        lines = 4'b0001;
        lin[3:0] = 4'hF;
        tick();
        chk("R3 capture LUT one", 32'(sout[0]), 32'h1);
        lin[3:0] = 4'h7;
        #1;
        chk("R5 registered ignores comb", 32'(sout[0]), 32'h1);
        @(posedge clk); #1; @(negedge clk);
        chk("R3 capture LUT zero", 32'(sout[0]), 32'h0);

        // R4: bypass from input 3 while the table returns 0.
        lines = 4'b0000;
        words[0] = mkw(16'h0000, 1'b1, 1'b1, 2'd0);
        load();
        lines = 4'b0001;
        lin[3:0] = 4'h8;
        tick();
        chk("R4 bypass one", 32'(sout[0]), 32'h1);
        lin[3:0] = 4'h7;
        tick();
        chk("R4 bypass zero", 32'(sout[0]), 32'h0);

        // R6: clock-line selection per slice.
        lines = 4'b0000;
        words[0] = mkw(16'h0, 1'b1, 1'b1, 2'd2);
        words[1] = mkw(16'h0, 1'b1, 1'b1, 2'd3);
        load();
        lin[3:0] = 4'h8; lin[7:4] = 4'h8;
        lines = 4'b0011;
        tick();
        chk("R6 unselected lines", 32'(sout[1:0]), 32'h0);
        lines = 4'b0100;
        tick();
        chk("R6 line 2 only", 32'(sout[1:0]), 32'h1);
        lines = 4'b1000;
        tick();
        chk("R6 line 3", 32'(sout[1:0]), 32'h3);

        // R9: hold across a reload with the selected line high.
        lines = 4'b0000;
        for (int s = 0; s < NS; s++) words[s] = mkw(16'h0, 1'b0, 1'b0, 2'd0);
        words[0] = mkw(16'h0, 1'b1, 1'b1, 2'd0);
        load();
        lines = 4'b0001;
        lin[3:0] = 4'h8;
        tick();
        chk("R9 preset one", 32'(sout[0]), 32'h1);
        lin[3:0] = 4'h0;
        load();
        lines = 4'b0000;
        @(negedge clk);
        chk("R9 flip-flop held", 32'(sout[0]), 32'h1);

        // R11: reset mid-run clears state and configuration.
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #1;
        chk("R11 mid-run reset", 32'(sout), 32'h0);
        chk("R11 chain cleared", 32'(cfg_out), 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule